// File: doc/BRIEF.md
# Instruction Fetch Word Queue

This block is a short queue placed between the response side of an instruction memory and the decode stage of a processor. Each cycle in which the memory side raises its input valid, the queue stores the returned 32-bit word together with its error flag. The oldest stored word is shown on a valid/ready output port, together with its error flag and the instruction address it belongs to.

The queue does not store an address for each entry. It keeps one head address. A flush, which is driven by a branch, loads that address from the target input and empties every entry. Each pop then adds 4 to it. The queue also drives a busy vector with one bit per reservable slot. The bits form a fill-level pattern. An upstream request generator ORs this vector with a bit-reversed copy of its in-flight request vector. If the result is all ones, no further fetch may be issued. The storage holds one entry more than the number of reservable slots. Because of that extra entry, a response that arrives while the head is being popped always finds room.

Top module: `fetch_word_queue`

## Requirements
- R1: After the asynchronous active-low reset, out_valid_o is 0 and busy_o is all zeros.
- R2: A word pushed into an empty queue is not visible in the cycle it arrives. out_valid_o rises at the next clock edge, and out_rdata_o and out_err_o then show the pushed word and its error flag.
- R3: Entries leave in the order they arrived. Storage fills from entry 0 upward. busy_o[i] is 1 exactly when entry i holds a word, so busy_o is 2'b01 with one entry and 2'b11 with two or more entries (default of 2 slots).
- R4: A push and a pop in the same cycle are both accepted, and the occupancy does not change.
- R5: A flush (clear_i high) empties the queue at the next edge. out_valid_o is then 0 and busy_o is 0, and a push or pop in the same cycle as the flush has no effect.
- R6: On a flush, the head address takes the value of target_addr_i. The first word pushed after the flush is shown with that address, including its two low bits.
- R7: Each pop (out_valid_o and out_ready_i both high, no flush) adds 4 to the head address.
- R8: The queue holds slots+1 words (3 by default). A push that arrives when the queue is full and no pop happens in that cycle is dropped.
- R9: While out_valid_o is high and out_ready_i is low, the output word, flag and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Flush all entries and load the head address |
| target_addr_i | input | 32 | Branch target loaded as the head address on flush |
| busy_o | output | SLOTS | Per-slot fill-level pattern |
| in_valid_i | input | 1 | A fetched word is present this cycle |
| in_rdata_i | input | 32 | Fetched instruction word |
| in_err_i | input | 1 | Fetch error flag for the word |
| out_valid_o | output | 1 | Head entry is valid |
| out_ready_i | input | 1 | Consumer accepts the head entry |
| out_rdata_o | output | 32 | Head instruction word |
| out_addr_o | output | 32 | Address of the head instruction |
| out_err_o | output | 1 | Error flag of the head entry |

## Verification
The queue is tested with a push into an empty queue and with filling it to capacity while the consumer stalls. Together these show the one-cycle visibility delay, the fill pattern on busy_o and the point at which an extra push is dropped. A push and a pop in the same cycle on a full queue show that both are accepted, which separates that case from an overflow. A flush that coincides with a push and a pop shows that the flush wins. A streamed run with alternating ready and mixed error flags follows, starting from an unaligned target. A scoreboard compares the word, the flag and the computed address of every popped entry, which tests ordering and the address step.

// File: rtl/fwq_pkg.sv
package fwq_pkg;
  localparam int unsigned FWQ_DW = 32;

  typedef struct packed {
    logic              err;
    logic [FWQ_DW-1:0] word;
  } fwq_entry_t;
endpackage

// File: rtl/fwq_store.sv
module fwq_store
  import fwq_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  fwq_entry_t       wr_entry,
  output logic [DEPTH-1:0] valid_o,
  output fwq_entry_t       head_o
);

  logic [DEPTH-1:0] valid_q, valid_d, valid_sh, wr_sel;
  fwq_entry_t       ent_q  [DEPTH];
  fwq_entry_t       ent_d  [DEPTH];
  fwq_entry_t       ent_sh [DEPTH];
  logic [DEPTH-1:0] ent_en;

  assign valid_sh = pop ? (valid_q >> 1) : valid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_top
      assign ent_sh[i] = ent_q[i];
      assign wr_sel[i] = push & ~valid_sh[i] & valid_sh[i-1];
    end else if (i == 0) begin : g_bot
      assign ent_sh[i] = pop ? ent_q[i+1] : ent_q[i];
      assign wr_sel[i] = push & ~valid_sh[i];
    end else begin : g_mid
      assign ent_sh[i] = pop ? ent_q[i+1] : ent_q[i];
      assign wr_sel[i] = push & ~valid_sh[i] & valid_sh[i-1];
    end

    always_comb begin
      valid_d[i] = flush ? 1'b0 : (valid_sh[i] | wr_sel[i]);
      ent_d[i]   = wr_sel[i] ? wr_entry : ent_sh[i];
      ent_en[i]  = ~flush & (pop | wr_sel[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (ent_en[i]) begin
        ent_q[i] <= ent_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign head_o  = ent_q[0];

  // R3
  thermo_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_q + 1'b1) & valid_q) == '0);

  // R4
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && pop) |=> ($countones(valid_q) == $past($countones(valid_q))));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/fwq_head.sv
module fwq_head #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          advance,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] StepVal = AW'(STEP);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | advance;
    if (load) begin
      addr_d = load_addr;
    end else begin
      addr_d = addr_q + StepVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R6
  head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == $past(load_addr)));

  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (addr_q == $past(addr_q) + StepVal));

endmodule

// File: rtl/fetch_word_queue.sv
module fetch_word_queue
  import fwq_pkg::*;
#(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned AW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [AW-1:0]     target_addr_i,
  output logic [SLOTS-1:0]  busy_o,
  input  logic              in_valid_i,
  input  logic [FWQ_DW-1:0] in_rdata_i,
  input  logic              in_err_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FWQ_DW-1:0] out_rdata_o,
  output logic [AW-1:0]     out_addr_o,
  output logic              out_err_o
);

  localparam int unsigned DEPTH = SLOTS + 1;
  localparam int unsigned STEP  = FWQ_DW / 8;

  logic [DEPTH-1:0] fill;
  fwq_entry_t       head_ent, in_ent;
  logic             pop;

  assign pop    = fill[0] & out_ready_i;
  assign in_ent = '{err: in_err_i, word: in_rdata_i};

  fwq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (clear_i),
    .push     (in_valid_i),
    .pop      (pop),
    .wr_entry (in_ent),
    .valid_o  (fill),
    .head_o   (head_ent)
  );

  fwq_head #(.AW(AW), .STEP(STEP)) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (clear_i),
    .load_addr (target_addr_i),
    .advance   (pop),
    .addr_o    (out_addr_o)
  );

  assign busy_o      = fill[SLOTS-1:0];
  assign out_valid_o = fill[0];
  assign out_rdata_o = head_ent.word;
  assign out_err_o   = head_ent.err;

  // R2
  empty_push_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid_o && in_valid_i && !clear_i) |=> (out_valid_o && out_rdata_o == $past(in_rdata_i)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !clear_i) |=>
      (out_valid_o && $stable(out_rdata_o) && $stable(out_err_o) && $stable(out_addr_o)));

endmodule

// File: tb/sim_fetch_word_queue.sv
`timescale 1ns/1ps
module sim_fetch_word_queue;
  localparam int SLOTS = 2;
  localparam int CAP   = SLOTS + 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clr;
  logic [31:0]      tgt;
  logic [SLOTS-1:0] busy;
  logic             in_v;
  logic [31:0]      in_d;
  logic             in_e;
  logic             out_v;
  logic             rdy;
  logic [31:0]      out_d;
  logic [31:0]      out_a;
  logic             out_e;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; logic e; } exp_t;
  exp_t exp_q[$];
  logic [31:0] base;
  int          nstored;

  always #10 clk = ~clk;

  fetch_word_queue #(.SLOTS(SLOTS), .AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .clear_i(clr), .target_addr_i(tgt), .busy_o(busy),
    .in_valid_i(in_v), .in_rdata_i(in_d), .in_err_i(in_e),
    .out_valid_o(out_v), .out_ready_i(rdy), .out_rdata_o(out_d),
    .out_addr_o(out_a), .out_err_o(out_e)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and records expected items
  task automatic drive(input bit v, input logic [31:0] d, input bit e, input bit r,
                       input bit c, input logic [31:0] a);
    bit popn;
    @(posedge clk);
    #2;
    in_v = v; in_d = d; in_e = e; rdy = r; clr = c; tgt = a;
    #1;
    if (c) begin
      exp_q.delete();
      base = a;
      nstored = 0;
    end else begin
      popn = out_v && r;
      if (v && (exp_q.size() < CAP || popn)) begin
        exp_q.push_back('{a: base + 32'(4 * nstored), d: d, e: e});
        nstored++;
      end
    end
  endtask

  // monitor: compares each accepted output against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !clr && out_v && rdy) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected pop", out_d, 32'h0);
      end else begin
        chk(out_d == exp_q[0].d, "R3 order/data", out_d, exp_q[0].d);
        chk(out_a == exp_q[0].a, "R7 address", out_a, exp_q[0].a);
        chk(out_e == exp_q[0].e, "R2 error flag", {31'b0, out_e}, {31'b0, exp_q[0].e});
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 0; tgt = '0; in_v = 0; in_d = '0; in_e = 0; rdy = 0;
    base = '0; nstored = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(out_v == 1'b0, "R1 valid", {31'b0, out_v}, 32'h0);
    chk(busy == '0, "R1 busy", 32'(busy), 32'h0);

    // flush to an unaligned target
    drive(0, 32'h0, 0, 0, 1, 32'h1000_0002);
    drive(1, 32'hA000_0001, 1, 0, 0, 32'h0);
    @(negedge clk);
    chk(out_v == 1'b0, "R2 not same cycle", {31'b0, out_v}, 32'h0);
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(out_v == 1'b1, "R2 visible next", {31'b0, out_v}, 32'h1);
    chk(out_d == 32'hA000_0001, "R2 data", out_d, 32'hA000_0001);
    chk(out_e == 1'b1, "R2 err", {31'b0, out_e}, 32'h1);
    chk(out_a == 32'h1000_0002, "R6 head addr", out_a, 32'h1000_0002);
    chk(busy == 2'b01, "R3 busy one", 32'(busy), 32'h1);

    drive(1, 32'hA000_0002, 0, 0, 0, 32'h0);
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(busy == 2'b11, "R3 busy two", 32'(busy), 32'h3);
    drive(1, 32'hA000_0003, 0, 0, 0, 32'h0);
    drive(1, 32'hDEAD_BEEF, 0, 0, 0, 32'h0);  // full, no pop: dropped
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(busy == 2'b11, "R8 busy full", 32'(busy), 32'h3);
    chk(exp_q.size() == CAP, "R8 stored count", 32'(exp_q.size()), 32'(CAP));
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(out_d == 32'hA000_0001, "R9 stall data", out_d, 32'hA000_0001);
    chk(out_a == 32'h1000_0002, "R9 stall addr", out_a, 32'h1000_0002);

    // push and pop together on a full queue
    drive(1, 32'hA000_0004, 1, 1, 0, 32'h0);
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(busy == 2'b11, "R4 level kept", 32'(busy), 32'h3);
    chk(out_a == 32'h1000_0006, "R7 step", out_a, 32'h1000_0006);

    for (int i = 0; i < 5; i++) drive(0, 32'h0, 0, 1, 0, 32'h0);
    @(negedge clk);
    chk(out_v == 1'b0, "R8 drained", {31'b0, out_v}, 32'h0);
    chk(exp_q.size() == 0, "R8 nothing left", 32'(exp_q.size()), 32'h0);

    // flush beats simultaneous push and pop
    drive(1, 32'hB000_0001, 0, 0, 0, 32'h0);
    drive(1, 32'hB000_0002, 0, 0, 0, 32'h0);
    drive(1, 32'hB000_0003, 0, 1, 1, 32'h2000_0000);
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(out_v == 1'b0, "R5 valid low", {31'b0, out_v}, 32'h0);
    chk(busy == '0, "R5 busy low", 32'(busy), 32'h0);
    drive(1, 32'hC000_0000, 0, 0, 0, 32'h0);
    drive(0, 32'h0, 0, 0, 0, 32'h0);
    @(negedge clk);
    chk(out_a == 32'h2000_0000, "R6 flush target", out_a, 32'h2000_0000);
    chk(out_d == 32'hC000_0000, "R5 no stale word", out_d, 32'hC000_0000);

    // streamed traffic with alternating ready
    for (int i = 0; i < 40; i++) begin
      drive((i % 5) != 4, 32'hE000_0000 + 32'(i), (i % 3) == 0, (i % 2) == 0, 0, 32'h0);
    end
    for (int i = 0; i < 6; i++) drive(0, 32'h0, 0, 1, 0, 32'h0);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 stream drained", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule